// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

This block frees a two-wire bus when a target device has stopped in the middle of a byte and is holding the data line low. While the data line is low, the master cannot produce a START condition. The sequencer can begin on a request strobe. It also begins by itself when the data line has stayed low for a set number of clock cycles while the clock line is high and the normal master reports no transfer in flight. Once started, it takes both line drivers from the normal master and clocks SCL with SDA released. This lets the stuck target shift out the rest of its byte.

After each clock pulse the sequencer samples SDA. A high level ends the pulse loop early. The loop is bounded at nine pulses. The sequencer then forces a STOP condition: SCL low, SDA pulled low, SCL released, and finally SDA released while SCL is high. Each step lasts one programmable half-period. A one-cycle done pulse reports that SDA came free. A fail pulse reports that SDA was still low after the last pulse. The STOP is issued in both cases.

The line inputs are expected to be already synchronised. The outputs are pull-low enables for external open-drain pads. A grant output tells the normal master when it may drive the bus.

Top module: `bus_unjam_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, scl_low_o and sda_low_o are 0 and grant_o is 1.
- R2: A start_i sampled high while idle makes busy_o high, and grant_o low, from the next cycle onward. A start_i sampled while busy_o is high has no effect on the sequence or its length.
- R3: Each recovery pulse pulls SCL low for N cycles and then releases it for N cycles, with SDA released throughout. N is half_per_i, and the value 0 is treated as 1.
- R4: SDA is sampled on the last cycle of each released-SCL phase. A high level ends the loop. No more than PULSES (9) pulses are generated.
- R5: After the loop, the STOP runs in four steps of N cycles each, in this order: SCL low with SDA released; both pulled low; SCL released with SDA low; both released. SDA is only pulled low while SCL is low, and it is released only while SCL is released. busy_o stays high for exactly (2P+4)*N cycles, where P is the number of pulses.
- R6: In the first cycle after busy_o falls, done_o pulses for one cycle if the last sample of SDA was high, and fail_o pulses for one cycle otherwise. The two are never high together.
- R7: While idle, if SDA is low, SCL is high and bus_busy_i is low for TIMEOUT_CYC consecutive clock edges, recovery starts by itself. busy_o is seen high after the TIMEOUT_CYC-th edge.
- R8: The stuck-line counter restarts whenever SDA is high, SCL is low or bus_busy_i is high. A low run that is shorter than TIMEOUT_CYC, or that occurs while bus_busy_i is high, starts nothing.
- R9: While busy_o is low, both pull-low outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Recovery request strobe |
| half_per_i | input | HALF_W | Half-period of a pulse, in clock cycles (0 acts as 1) |
| bus_busy_i | input | 1 | Normal master has a transfer in flight |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| grant_o | output | 1 | Normal master may drive the lines |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse: bus freed |
| fail_o | output | 1 | One-cycle pulse: SDA still low after the last pulse |

## Verification
Two events can fall in the same cycle. The first is the SDA sample that ends the pulse loop, which happens on the last cycle of a high phase. The second is the last permitted pulse. Both land together when the target lets go on exactly the ninth rising SCL edge. The bench covers this by running a target model that releases SDA after K rising edges, with K swept across and beyond nine and several half-periods. The outcome is judged on three things: whether done or fail pulses, the exact busy length computed as (2P+4)*N, and whether a STOP edge appears on the lines. A second overlap, a start strobe arriving mid-sequence, is checked to leave the busy length unchanged.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STP_PRE,
    ST_STP_SDA,
    ST_STP_SCL,
    ST_STP_REL
  } unjam_state_e;
endpackage

// File: rtl/bus_unjam_phase_timer.sv
module bus_unjam_phase_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] len_i,
  output logic              expire_o
);
  logic [HALF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/bus_unjam_stuck_timer.sv
module bus_unjam_stuck_timer #(
  parameter int TIMEOUT_CYC = 3_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic sda_i,
  output logic fire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          low_run;

  assign low_run = arm_i && !sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!low_run)        cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = low_run && (cnt_q == LAST);
endmodule

// File: rtl/bus_unjam_fsm.sv
module bus_unjam_fsm
  import bus_unjam_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic expire_i,
  input  logic sda_i,
  output logic load_o,
  output logic idle_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic done_o,
  output logic fail_o
);
  localparam int PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] PLAST = PW'(PULSES - 1);

  unjam_state_e st_q, st_d;
  logic [PW-1:0] pcnt_q;
  logic          ok_q, done_q, fail_q;
  logic          hi_end;

  assign hi_end = (st_q == ST_CLK_HI) && expire_i;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (go_i) begin st_d = ST_CLK_LO; load_o = 1'b1; end
      ST_CLK_LO:  if (expire_i) begin st_d = ST_CLK_HI; load_o = 1'b1; end
      ST_CLK_HI:  if (expire_i) begin
                    st_d   = (sda_i || pcnt_q == PLAST) ? ST_STP_PRE : ST_CLK_LO;
                    load_o = 1'b1;
                  end
      ST_STP_PRE: if (expire_i) begin st_d = ST_STP_SDA; load_o = 1'b1; end
      ST_STP_SDA: if (expire_i) begin st_d = ST_STP_SCL; load_o = 1'b1; end
      ST_STP_SCL: if (expire_i) begin st_d = ST_STP_REL; load_o = 1'b1; end
      ST_STP_REL: if (expire_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      if (st_q == ST_IDLE)  pcnt_q <= '0;
      else if (hi_end)      pcnt_q <= pcnt_q + 1'b1;
      if (hi_end)           ok_q   <= sda_i;
      if (st_q == ST_STP_REL && expire_i) begin
        done_q <= ok_q;
        fail_q <= !ok_q;
      end
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign scl_low_o = (st_q == ST_CLK_LO) || (st_q == ST_STP_PRE) || (st_q == ST_STP_SDA);
  assign sda_low_o = (st_q == ST_STP_SDA) || (st_q == ST_STP_SCL);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq #(
  parameter int HALF_W      = 8,
  parameter int PULSES      = 9,
  parameter int TIMEOUT_CYC = 3_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic              bus_busy_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              grant_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  logic load, expire, idle, fire, arm;

  assign arm = idle && scl_i && !bus_busy_i;

  bus_unjam_phase_timer #(.HALF_W(HALF_W)) i_phase (
    .clk_i, .rst_ni, .load_i(load), .len_i(half_per_i), .expire_o(expire)
  );

  bus_unjam_stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_stuck (
    .clk_i, .rst_ni, .arm_i(arm), .sda_i, .fire_o(fire)
  );

  bus_unjam_fsm #(.PULSES(PULSES)) i_fsm (
    .clk_i, .rst_ni, .go_i(start_i || fire), .expire_i(expire), .sda_i,
    .load_o(load), .idle_o(idle), .scl_low_o, .sda_low_o, .done_o, .fail_o
  );

  assign busy_o  = !idle;
  assign grant_o = idle;
endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk #(
  parameter int PULSES = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  localparam int CW = $clog2(PULSES + 3);
  logic [CW-1:0] falls_q;
  logic          scl_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      falls_q   <= '0;
      scl_low_q <= 1'b0;
    end else begin
      scl_low_q <= scl_low_o;
      if (!busy_o)                     falls_q <= '0;
      else if (scl_low_o && !scl_low_q) falls_q <= falls_q + 1'b1;
    end
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_pulse_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    falls_q <= CW'(PULSES + 1));

  assert_sda_pull_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> scl_low_o);

  assert_stop_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_low_o) |-> (!scl_low_o && $past(!scl_low_o)));

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> (!busy_o && $past(busy_o)));

  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o));
endmodule

bind bus_unjam_seq bus_unjam_chk #(.PULSES(PULSES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .scl_low_o(scl_low_o),
  .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/test_bus_unjam_seq.sv
module test_bus_unjam_seq;
  localparam int HALF_W = 8;
  localparam int TOUT   = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [HALF_W-1:0] half_per_i = 8'd1;
  logic bus_busy_i = 1'b0;
  logic scl_i, sda_i;
  logic scl_low_o, sda_low_o, grant_o, busy_o, done_o, fail_o;

  int tests = 0, fails = 0, cycles = 0;
  int rises = 0, stops = 0, base_r = 0, kq = 0;
  bit armed = 0, stuck = 0, prev_scl = 1, prev_sda = 1;

  always #4 clk_i = ~clk_i;

  assign scl_i = ~scl_low_o;
  assign sda_i = ~(sda_low_o | (armed && (rises - base_r) < kq) | stuck);

  bus_unjam_seq #(.HALF_W(HALF_W), .PULSES(9), .TIMEOUT_CYC(TOUT)) i_bus_unjam_seq (
    .clk_i, .rst_ni, .start_i, .half_per_i, .bus_busy_i, .scl_i, .sda_i,
    .scl_low_o, .sda_low_o, .grant_o, .busy_o, .done_o, .fail_o
  );

  always @(negedge clk_i) begin
    cycles++;
    if (!prev_scl && scl_i) rises++;
    if (prev_scl && scl_i && !prev_sda && sda_i) stops++;
    prev_scl = scl_i;
    prev_sda = sda_i;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_case(input int n, input int k, input bit poke);
    int eff, p, exp_busy, cyc, lo, base_s;
    bit exp_ok, exp_stop, seen_hi;
    eff = (n == 0) ? 1 : n;
    p = (k <= 1) ? 1 : ((k > 9) ? 9 : k);
    exp_busy = (2 * p + 4) * eff;
    exp_ok = (k <= 9);
    exp_stop = (k <= 10);
    @(negedge clk_i);
    half_per_i = HALF_W'(n);
    kq = k;
    base_r = rises;
    base_s = stops;
    armed = 1;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    check(busy_o == 1 && grant_o == 0, "R2", "busy/grant after start", {busy_o, grant_o}, 2);
    cyc = 0; lo = 0; seen_hi = 0;
    while (busy_o && cyc < 1000) begin
      cyc++;
      if (!seen_hi) begin
        if (!scl_i) lo++; else seen_hi = 1;
      end
      if (!scl_i && !seen_hi && sda_i == 0 && (rises - base_r) >= kq)
        check(0, "R3", "sda pulled during pulse", 0, 1);
      @(negedge clk_i);
      start_i = poke && (cyc == 3);
    end
    start_i = 0;
    check(done_o == exp_ok, "R6", "done pulse", done_o, exp_ok);
    check(fail_o == !exp_ok, "R6", "fail pulse", fail_o, !exp_ok);
    check(cyc == exp_busy, poke ? "R2" : "R5", "busy length", cyc, exp_busy);
    check(lo == eff, "R3", "first low phase", lo, eff);
    @(negedge clk_i);
    check(done_o == 0 && fail_o == 0, "R6", "report one cycle", {done_o, fail_o}, 0);
    check(rises - base_r == p + 1, "R4", "scl rising edges", rises - base_r, p + 1);
    check((stops - base_s > 0) == exp_stop, "R5", "stop seen", stops - base_s, exp_stop);
    armed = 0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && scl_low_o == 0 && sda_low_o == 0, "R9", "idle released",
          {busy_o, scl_low_o, sda_low_o}, 0);
  endtask

  initial begin
    int found;
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && done_o == 0 && fail_o == 0, "R1", "status at reset",
          {busy_o, done_o, fail_o}, 0);
    check(scl_low_o == 0 && sda_low_o == 0 && grant_o == 1, "R1", "lines at reset",
          {scl_low_o, sda_low_o, grant_o}, 1);
    rst_ni = 1;
    @(negedge clk_i);
    check(busy_o == 0 && grant_o == 1, "R1", "idle after reset", {busy_o, grant_o}, 1);

    // sweep half-period and release point
    for (int n = 0; n <= 3; n++)
      for (int k = 0; k <= 11; k++)
        run_case(n, k, 0);

    // start strobe during a run
    run_case(2, 5, 1);
    run_case(1, 11, 1);

    // R8: low while master busy
    @(negedge clk_i);
    bus_busy_i = 1; stuck = 1;
    found = 0;
    for (int i = 0; i < 3 * TOUT; i++) begin
      @(negedge clk_i);
      if (busy_o) found = 1;
    end
    check(found == 0, "R8", "no trigger while master busy", found, 0);
    stuck = 0; bus_busy_i = 0;

    // R8: short low runs separated by a high cycle
    found = 0;
    for (int r = 0; r < 3; r++) begin
      stuck = 1;
      repeat (TOUT - 1) begin @(negedge clk_i); if (busy_o) found = 1; end
      stuck = 0;
      @(negedge clk_i); if (busy_o) found = 1;
    end
    repeat (5) begin @(negedge clk_i); if (busy_o) found = 1; end
    check(found == 0, "R8", "no trigger on short runs", found, 0);

    // R7: timeout start, then bus freed
    half_per_i = 8'd2;
    stuck = 1;
    found = 0;
    for (int i = 1; i <= 3 * TOUT && found == 0; i++) begin
      @(negedge clk_i);
      if (busy_o) found = i;
    end
    check(found == TOUT, "R7", "timeout start cycle", found, TOUT);
    stuck = 0;
    found = 0;
    for (int i = 0; i < 100 && busy_o; i++) @(negedge clk_i);
    check(done_o == 1 && fail_o == 0, "R7", "timeout run done", {done_o, fail_o}, 2);

    // R7: timeout start with line never freed
    repeat (3) @(negedge clk_i);
    stuck = 1;
    for (int i = 0; i < 3 * TOUT && !busy_o; i++) @(negedge clk_i);
    check(busy_o == 1, "R7", "timeout start fail case", busy_o, 1);
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk_i);
    check(fail_o == 1 && done_o == 0, "R6", "stuck run fails", {done_o, fail_o}, 1);
    stuck = 0;
    repeat (4) @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule